// File: doc/BRIEF.md
# Interrupt Controller Command-Word Decoder

This block is the programming front end of an ISA-compatible eight-input interrupt controller. It watches CPU I/O writes, decodes the two ports that belong to one controller (a command port at a fixed base address and a data port one above it), and runs the start-up handshake. The start-up handshake is one command-port word followed by exactly three data-port words. Once that handshake is done, writes are routed to the operational registers: the request mask, the end-of-interrupt/rotation command, and the readback, special-mask and poll settings.

The block holds the captured configuration and shows it on its outputs. It also issues one-cycle command pulses to the priority and service logic downstream, which is not part of this block. A chip has one instance per controller: one with the base address parameter set to 0x20 and one with it set to 0xA0.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset, `initBusy` is 1, `irqMask`, `vectorBase`, `cascadeMap`, `modeWord`, `ocw2Cmd` and `ocw2Level` are 0, and `readIsr`, `specialMask`, `singleMode`, `ocw2Valid` and `pollReq` are 0.
- R2: Only writes to address `BASE_ADDR` (the command port) and `BASE_ADDR`+1 (the data port) have any effect. The supported bases are 0x20 and 0xA0, and a write to the other controller's ports changes nothing.
- R3: A command-port write with data bit 4 = 1 starts the start-up sequence, or restarts it at any point. On that write, `initBusy` becomes 1, `irqMask` clears to 0, `readIsr` and `specialMask` clear to 0, and `singleMode` takes data bit 1.
- R4: The next three data-port writes are captured in order. The first sets `vectorBase` from data bits 7:3, the second sets `cascadeMap` from the whole byte, and the third sets `modeWord` from data bits 4:0. `initBusy` falls only after the third of them, whatever bits 0 and 1 of the first word held.
- R5: Data bit 3 of the start word is not stored. Two sequences that differ only in that bit leave every output identical.
- R6: While `initBusy` is 1, command-port writes with bit 4 = 0 give no pulse and change no setting. Data-port writes outside the sequence leave `irqMask` unchanged.
- R7: When `initBusy` is 0, a data-port write loads `irqMask` with the data byte. A 1 bit masks the matching request input.
- R8: When `initBusy` is 0, a command-port write with bit 4 = 0 and bit 3 = 0 raises `ocw2Valid` for one cycle. During that cycle, `ocw2Cmd` holds data bits 7:5 (rotate, specific, end-of-interrupt) and `ocw2Level` holds data bits 2:0.
- R9: When `initBusy` is 0, a command-port write with bit 4 = 0 and bit 3 = 1 acts as follows. If bit 1 is set, `readIsr` takes bit 0. If bit 6 is set, `specialMask` takes bit 5. If bit 2 is set, `pollReq` pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | I/O write valid this cycle |
| wrAddr | input | ADDR_W | I/O write address |
| wrData | input | 8 | I/O write data byte |
| initBusy | output | 1 | Start-up sequence not yet complete |
| singleMode | output | 1 | No-cascade flag from the start word |
| vectorBase | output | 5 | Upper vector bits from the second word |
| cascadeMap | output | 8 | Cascade configuration byte from the third word |
| modeWord | output | 5 | Mode bits from the fourth word |
| irqMask | output | 8 | Request mask, 1 = masked |
| readIsr | output | 1 | Readback select: 1 = in-service, 0 = request register |
| specialMask | output | 1 | Special mask mode enabled |
| ocw2Valid | output | 1 | One-cycle EOI/rotation command pulse |
| ocw2Cmd | output | 3 | Rotate/specific/EOI bits of that command |
| ocw2Level | output | 3 | Level field of that command |
| pollReq | output | 1 | One-cycle poll request pulse |

## Verification
The bench starts the sequence with a first word that claims a short sequence (single mode, no fourth word). It then checks that `initBusy` stays high through the second and third words. A design that honoured those bits would release early and read the fourth word as a mask. The bench restarts the sequence halfway through and checks that counting begins again and the mask is cleared. It fires operational words before start-up finishes, where a leaky gate would give stray pulses or change readback settings. It writes to the other controller's ports and toggles only the trigger bit between two sequences. A careless address compare, or storage of the trigger bit, would show up in the outputs.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_WORD2  = 3'd1,
    ST_WORD3  = 3'd2,
    ST_WORD4  = 3'd3,
    ST_READY  = 3'd4
  } seqState_t;

  typedef struct packed {
    logic ldStart;
    logic ldVector;
    logic ldCascade;
    logic ldMode;
    logic ldMask;
    logic doEoi;
    logic doMisc;
  } cmdStrobe_t;

endpackage

// File: rtl/pic_cmd_ctrl.sv
module pic_cmd_ctrl
  import pic_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0020
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              selBit4,
  input  logic              selBit3,
  output cmdStrobe_t        strobe,
  output logic              initBusy
);
  localparam logic [ADDR_W-1:0] DATA_PORT = BASE_ADDR + 1'b1;

  seqState_t state, stateNext;
  logic hitCmd, hitData;

  assign hitCmd  = wrEn && (wrAddr == BASE_ADDR);
  assign hitData = wrEn && (wrAddr == DATA_PORT);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (hitCmd && selBit4) begin
      strobe.ldStart = 1'b1;
      stateNext      = ST_WORD2;
    end else begin
      unique case (state)
        ST_WORD2: if (hitData) begin strobe.ldVector  = 1'b1; stateNext = ST_WORD3; end
        ST_WORD3: if (hitData) begin strobe.ldCascade = 1'b1; stateNext = ST_WORD4; end
        ST_WORD4: if (hitData) begin strobe.ldMode    = 1'b1; stateNext = ST_READY; end
        ST_READY: begin
          strobe.ldMask = hitData;
          strobe.doEoi  = hitCmd && !selBit3;
          strobe.doMisc = hitCmd && selBit3;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_UNINIT;
    else       state <= stateNext;
  end

  assign initBusy = (state != ST_READY);
endmodule

// File: rtl/pic_cmd_regs.sv
module pic_cmd_regs
  import pic_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              singleMode,
  output logic [4:0]        vectorBase,
  output logic [DATA_W-1:0] cascadeMap,
  output logic [4:0]        modeWord,
  output logic [DATA_W-1:0] irqMask,
  output logic              readIsr,
  output logic              specialMask,
  output logic              ocw2Valid,
  output logic [2:0]        ocw2Cmd,
  output logic [2:0]        ocw2Level,
  output logic              pollReq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      singleMode  <= 1'b0;
      vectorBase  <= '0;
      cascadeMap  <= '0;
      modeWord    <= '0;
      irqMask     <= '0;
      readIsr     <= 1'b0;
      specialMask <= 1'b0;
      ocw2Valid   <= 1'b0;
      ocw2Cmd     <= '0;
      ocw2Level   <= '0;
      pollReq     <= 1'b0;
    end else begin
      ocw2Valid <= strobe.doEoi;
      pollReq   <= strobe.doMisc && wrData[2];
      if (strobe.ldStart) begin
        singleMode  <= wrData[1];
        irqMask     <= '0;
        readIsr     <= 1'b0;
        specialMask <= 1'b0;
      end
      if (strobe.ldVector)  vectorBase <= wrData[7:3];
      if (strobe.ldCascade) cascadeMap <= wrData;
      if (strobe.ldMode)    modeWord   <= wrData[4:0];
      if (strobe.ldMask)    irqMask    <= wrData;
      if (strobe.doEoi) begin
        ocw2Cmd   <= wrData[7:5];
        ocw2Level <= wrData[2:0];
      end
      if (strobe.doMisc) begin
        if (wrData[1]) readIsr     <= wrData[0];
        if (wrData[6]) specialMask <= wrData[5];
      end
    end
  end
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
  import pic_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0020
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic              initBusy,
  output logic              singleMode,
  output logic [4:0]        vectorBase,
  output logic [7:0]        cascadeMap,
  output logic [4:0]        modeWord,
  output logic [7:0]        irqMask,
  output logic              readIsr,
  output logic              specialMask,
  output logic              ocw2Valid,
  output logic [2:0]        ocw2Cmd,
  output logic [2:0]        ocw2Level,
  output logic              pollReq
);
  cmdStrobe_t strobe;

  pic_cmd_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .selBit4(wrData[4]), .selBit3(wrData[3]),
    .strobe(strobe), .initBusy(initBusy)
  );

  pic_cmd_regs #(.DATA_W(8)) regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .singleMode(singleMode), .vectorBase(vectorBase), .cascadeMap(cascadeMap),
    .modeWord(modeWord), .irqMask(irqMask), .readIsr(readIsr),
    .specialMask(specialMask), .ocw2Valid(ocw2Valid), .ocw2Cmd(ocw2Cmd),
    .ocw2Level(ocw2Level), .pollReq(pollReq)
  );
endmodule

// File: rtl/pic_cmd_decoder_chk.sv
module pic_cmd_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0020
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic              initBusy,
  input logic [4:0]        vectorBase,
  input logic [7:0]        irqMask,
  input logic              readIsr,
  input logic              ocw2Valid,
  input logic [2:0]        ocw2Cmd,
  input logic              pollReq
);
  localparam logic [ADDR_W-1:0] DATA_PORT = BASE_ADDR + 1'b1;

  logic hitCmd, hitData;
  assign hitCmd  = wrEn && (wrAddr == BASE_ADDR);
  assign hitData = wrEn && (wrAddr == DATA_PORT);

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(hitCmd || hitData) |=> $stable(irqMask) && $stable(vectorBase) && !ocw2Valid && !pollReq);

  p_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hitCmd && wrData[4]) |=> initBusy && (irqMask == 8'h00) && !readIsr);

  p_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(initBusy) |-> $past(hitData));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ocw2Valid || pollReq) |-> !$past(initBusy));

  p_mask_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hitData && !initBusy) |=> irqMask == $past(wrData));

  p_eoi_fire_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hitCmd && !wrData[4] && !wrData[3] && !initBusy) |=> ocw2Valid && (ocw2Cmd == $past(wrData[7:5])));

  p_poll_r9: assert property (@(posedge clk) disable iff (!rstN)
    pollReq |-> $past(hitCmd && !wrData[4] && wrData[3] && wrData[2]));
endmodule

bind pic_cmd_decoder pic_cmd_decoder_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .initBusy(initBusy), .vectorBase(vectorBase), .irqMask(irqMask),
  .readIsr(readIsr), .ocw2Valid(ocw2Valid), .ocw2Cmd(ocw2Cmd), .pollReq(pollReq)
);

// File: tb/pic_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module pic_cmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;

  logic       initBusy, singleMode, readIsr, specialMask, ocw2Valid, pollReq;
  logic [4:0] vectorBase, modeWord;
  logic [7:0] cascadeMap, irqMask;
  logic [2:0] ocw2Cmd, ocw2Level;

  logic       sBusy, sSingle, sReadIsr, sSpecial, sValid, sPoll;
  logic [4:0] sVector, sMode;
  logic [7:0] sCascade, sMask;
  logic [2:0] sCmd, sLevel;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pic_cmd_decoder #(.ADDR_W(16), .BASE_ADDR(16'h0020)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .initBusy(initBusy), .singleMode(singleMode), .vectorBase(vectorBase),
    .cascadeMap(cascadeMap), .modeWord(modeWord), .irqMask(irqMask),
    .readIsr(readIsr), .specialMask(specialMask), .ocw2Valid(ocw2Valid),
    .ocw2Cmd(ocw2Cmd), .ocw2Level(ocw2Level), .pollReq(pollReq)
  );

  pic_cmd_decoder #(.ADDR_W(16), .BASE_ADDR(16'h00A0)) dutSec_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .initBusy(sBusy), .singleMode(sSingle), .vectorBase(sVector),
    .cascadeMap(sCascade), .modeWord(sMode), .irqMask(sMask),
    .readIsr(sReadIsr), .specialMask(sSpecial), .ocw2Valid(sValid),
    .ocw2Cmd(sCmd), .ocw2Level(sLevel), .pollReq(sPoll)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive on a falling edge, hold across one rising edge, return on the next falling edge.
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [63:0] snap();
    return {initBusy, singleMode, vectorBase, cascadeMap, modeWord, irqMask,
            readIsr, specialMask, ocw2Cmd, ocw2Level};
  endfunction

  task automatic startUp(input logic [7:0] w1, input logic [7:0] w2,
                         input logic [7:0] w3, input logic [7:0] w4);
    wr(16'h0020, w1); wr(16'h0021, w2); wr(16'h0021, w3); wr(16'h0021, w4);
  endtask

  task automatic t_reset();
    check("R1 busy", initBusy, 1);
    check("R1 regs", {irqMask, vectorBase, cascadeMap, modeWord, ocw2Cmd, ocw2Level}, 0);
    check("R1 flags", {readIsr, specialMask, singleMode, ocw2Valid, pollReq}, 0);
  endtask

  task automatic t_before_init();
    wr(16'h0020, 8'h20);
    check("R6 no eoi before init", ocw2Valid, 0);
    wr(16'h0021, 8'hFF);
    check("R6 mask untouched before init", irqMask, 8'h00);
    wr(16'h0020, 8'h0F);
    check("R6 no poll/readback before init", {pollReq, readIsr}, 0);
  endtask

  task automatic t_four_words();
    // start word claims single mode (bit1) and no fourth word (bit0=0)
    wr(16'h0020, 8'h12);
    check("R3 busy after start", initBusy, 1);
    check("R3 single flag", singleMode, 1);
    wr(16'h0020, 8'h0B);
    check("R6 readback ignored mid-sequence", readIsr, 0);
    wr(16'h0021, 8'h48);
    check("R4 vector", vectorBase, 5'h09);
    check("R4 busy after word2", initBusy, 1);
    wr(16'h0021, 8'h04);
    check("R4 cascade", cascadeMap, 8'h04);
    check("R4 busy after word3", initBusy, 1);
    check("R6 mask not loaded in sequence", irqMask, 8'h00);
    wr(16'h0021, 8'h1D);
    check("R4 mode", modeWord, 5'h1D);
    check("R4 released after word4", initBusy, 0);
  endtask

  task automatic t_mask();
    wr(16'h0021, 8'hA5);
    check("R7 mask A5", irqMask, 8'hA5);
    wr(16'h0021, 8'h3C);
    check("R7 mask 3C", irqMask, 8'h3C);
  endtask

  task automatic t_eoi();
    wr(16'h0020, 8'h20);
    check("R8 pulse", ocw2Valid, 1);
    check("R8 cmd/level", {ocw2Cmd, ocw2Level}, {3'b001, 3'd0});
    @(negedge clk);
    check("R8 one cycle", ocw2Valid, 0);
    wr(16'h0020, 8'hE5);
    check("R8 rotate specific", {ocw2Valid, ocw2Cmd, ocw2Level}, {1'b1, 3'b111, 3'd5});
    check("R8 mask untouched", irqMask, 8'h3C);
  endtask

  task automatic t_misc();
    wr(16'h0020, 8'h0B);
    check("R9 select ISR", readIsr, 1);
    wr(16'h0020, 8'h09);
    check("R9 no RR keeps ISR", readIsr, 1);
    wr(16'h0020, 8'h0A);
    check("R9 select IRR", readIsr, 0);
    wr(16'h0020, 8'h68);
    check("R9 special on", specialMask, 1);
    wr(16'h0020, 8'h28);
    check("R9 no ESMM keeps special", specialMask, 1);
    wr(16'h0020, 8'h0C);
    check("R9 poll pulse", {pollReq, ocw2Valid}, 2'b10);
    @(negedge clk);
    check("R9 poll one cycle", pollReq, 0);
    wr(16'h0020, 8'h48);
    check("R9 special off", specialMask, 0);
  endtask

  task automatic t_restart();
    wr(16'h0020, 8'h0B);
    wr(16'h0020, 8'h68);
    wr(16'h0021, 8'hF0);
    wr(16'h0020, 8'h11);
    check("R3 restart clears", {initBusy, irqMask, readIsr, specialMask, singleMode}, {1'b1, 8'h00, 3'b000});
    wr(16'h0021, 8'h40);
    wr(16'h0020, 8'h11);
    wr(16'h0021, 8'h80);
    check("R3 recount word2", {vectorBase, initBusy}, {5'h10, 1'b1});
    wr(16'h0021, 8'h02);
    wr(16'h0021, 8'h01);
    check("R3 recount done", {cascadeMap, modeWord, initBusy}, {8'h02, 5'h01, 1'b0});
  endtask

  task automatic t_trigger_bit();
    logic [63:0] a;
    startUp(8'h11, 8'h70, 8'h08, 8'h03);
    a = snap();
    startUp(8'h19, 8'h70, 8'h08, 8'h03);
    check("R5 trigger bit no effect", snap(), a);
  endtask

  task automatic t_decode();
    logic [63:0] a;
    a = snap();
    wr(16'h0022, 8'h11);
    wr(16'h0121, 8'hFF);
    check("R2 stray ports ignored", snap(), a);
    startUp(16'h0000 | 8'h11, 8'h00, 8'h00, 8'h00);
    a = snap();
    wr(16'h00A0, 8'h13);
    wr(16'h00A1, 8'hB8);
    wr(16'h00A1, 8'h02);
    wr(16'h00A1, 8'h01);
    wr(16'h00A1, 8'hFF);
    check("R2 primary ignores secondary ports", snap(), a);
    check("R2 secondary captured", {sBusy, sVector, sCascade, sMode, sMask}, {1'b0, 5'h17, 8'h02, 5'h01, 8'hFF});
    wr(16'h0021, 8'h81);
    check("R2 secondary ignores primary", sMask, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_before_init();
    t_four_words();
    t_mask();
    t_eoi();
    t_misc();
    t_restart();
    t_trigger_bit();
    t_decode();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule